// File: doc/BRIEF.md
# Descriptor Command Sequencer

This block is the per-channel engine of a descriptor-driven DMA channel. Software builds a chain of 16-byte command descriptors in memory and loads the chain's start address into the command pointer. The engine then walks the chain. For each descriptor it fetches the command, decodes it and executes it. A command is one of four things: a data-stream transfer handed to the device through a start/done handshake, a one-, two- or four-byte load or store of a system-space word, a no-op, or a stop.

Every command carries three 2-bit modes: wait, interrupt and branch. Each mode is tested against a masked match of the device-status bits. When a command completes, the engine first holds while the wait condition is true. It then writes the status word and the residual count back into the descriptor, clears the flush flag and raises the interrupt if that mode asks for it. Finally it either moves to the next descriptor at pointer+16 or jumps to the branch target held in the descriptor's command-dependent word. Malformed commands kill the channel.

Top module: `dsq_engine`

## Requirements
- R1: After reset the status word, command pointer and interrupt are zero, and no memory request or transfer start is issued.
- R2: A pointer write is accepted only while RUN and ACTIVE are both clear, and its low 4 bits are forced to zero. While RUN and ACTIVE are set and the engine is idle, it fetches descriptor words at pointer+0, +4 and +8. Word 0 carries the request count in [15:0] and the command in [31:16], word 1 the data address, and word 2 the command-dependent word. A memory request holds its address until acknowledged.
- R3: Command bits [15:12] give the operation: 0 output, 1 output-last, 2 input, 3 input-last, 4 store-word, 5 load-word, 6 no-op, 7 stop. Operation codes 8 to 15 are invalid. Key 4 (bits [10:8]) is invalid for every command. A transfer is invalid with a key above 3 or a zero data address. Load-word and store-word are invalid with any key other than 6.
- R4: An invalid command sets DEAD, clears ACTIVE, raises the interrupt and writes nothing to memory.
- R5: A transfer pulses the start output for one cycle. That pulse carries the direction (output for operations 0 and 1), the last flag (operation bit 0), the key, the address and the request count. The residual reported with done becomes the residual field; other commands write a residual of 0.
- R6: A condition is true when (device status[3:0] AND mask) equals (value AND mask). Each mode encodes 0 never, 1 when true, 2 when false, 3 always. Wait, interrupt and branch each have their own mask and value.
- R7: While the wait mode holds, the engine stalls before any write-back and re-evaluates the condition every cycle.
- R8: The write-back writes the command-dependent word to pointer+8, then {status, residual} to pointer+12. The status word has RUN at bit 15, ACTIVE 14, DEAD 13, BT 12, FLUSH 11, WAKE 10 and device status in [7:0].
- R9: FLUSH stays set through the write-back and is cleared after it. The interrupt is then raised if the interrupt mode holds.
- R10: If the branch mode holds, the pointer loads the command-dependent word and BT is set. Otherwise the pointer advances by 16 and BT is cleared. Load-word and store-word never branch.
- R11: For load-word and store-word, request-count bit 2 selects 4 bytes (byte enables 1111). Otherwise bit 1 selects 2 bytes (0011). Otherwise the access is 1 byte (0001). A store drives the command-dependent word as data. A load replaces the enabled low bytes of the command-dependent word.
- R12: A stop clears ACTIVE, DEAD and FLUSH, leaves the pointer unchanged and writes nothing.
- R13: WAKE is cleared when a descriptor fetch begins. The interrupt is a level that stays high until the acknowledge input is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run enable; rising edge sets ACTIVE, falling edge clears ACTIVE and DEAD |
| flush_req_i | input | 1 | Pulse that sets FLUSH |
| wake_req_i | input | 1 | Pulse that sets WAKE |
| ptr_wr_i | input | 1 | Command pointer write strobe |
| ptr_wdata_i | input | ADDR_W | Command pointer write value |
| cmd_ptr_o | output | ADDR_W | Current command pointer |
| status_o | output | 16 | Channel status word |
| dev_stat_i | input | DSTAT_W | Device status bits |
| wait_mask_i | input | SEL_W | Wait condition mask |
| wait_val_i | input | SEL_W | Wait condition value |
| irq_mask_i | input | SEL_W | Interrupt condition mask |
| irq_val_i | input | SEL_W | Interrupt condition value |
| br_mask_i | input | SEL_W | Branch condition mask |
| br_val_i | input | SEL_W | Branch condition value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Completes the request at this clock edge |
| xfer_start_o | output | 1 | Transfer start pulse |
| xfer_out_o | output | 1 | Transfer direction, 1 = memory to stream |
| xfer_last_o | output | 1 | Transfer ends the stream |
| xfer_key_o | output | 3 | Stream key |
| xfer_addr_o | output | ADDR_W | Transfer data address |
| xfer_len_o | output | 16 | Requested byte count |
| xfer_done_i | input | 1 | Transfer completion pulse |
| xfer_resid_i | input | 16 | Bytes left over, valid with done |
| irq_o | output | 1 | Interrupt level |
| irq_ack_i | input | 1 | Interrupt acknowledge |

## Verification
The embedded assertions check on every cycle that a memory request holds its address until acknowledged and that a transfer start lasts one cycle. They also check that the write-back targets only offsets 8 and 12, that word accesses use only the three legal byte-enable patterns, that the engine issues no request while the wait condition holds, that a kill or a stop leaves the status word in its required state one cycle later, and that the interrupt level drops only on acknowledge. Several behaviours need whole scenarios to show: the mode and condition decoding against random masks and status, the write-back contents, the branch-or-advance choice with the BT bit, the load merge, the store byte lanes, and the absence of memory writes on a kill or a stop. The bench drives those scenarios and compares the results against values it computes itself.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

   localparam int DESC_BYTES = 16;
   localparam int WORD_W     = 32;
   localparam int STAT_W     = 16;

   localparam int ST_RUN   = 15;
   localparam int ST_ACT   = 14;
   localparam int ST_DEAD  = 13;
   localparam int ST_BT    = 12;
   localparam int ST_FLUSH = 11;
   localparam int ST_WAKE  = 10;

   localparam logic [3:0] OP_STORE = 4'd4;
   localparam logic [3:0] OP_LOAD  = 4'd5;
   localparam logic [3:0] OP_NOP   = 4'd6;
   localparam logic [3:0] OP_STOP  = 4'd7;
   localparam logic [2:0] KEY_BAD  = 3'd4;
   localparam logic [2:0] KEY_SYS  = 3'd6;

   typedef enum logic [3:0] {
      S_IDLE, S_FETCH, S_DECODE, S_XSTART, S_XWAIT,
      S_MEMOP, S_COND, S_WB, S_FIN
   } dsq_state_e;

   // byte enables of a word access from the low request-count bits
   function automatic logic [3:0] word_be(input logic [2:0] rc);
      if (rc[2])      return 4'b1111;
      else if (rc[1]) return 4'b0011;
      else            return 4'b0001;
   endfunction

endpackage

// File: rtl/dsq_cond.sv
module dsq_cond #(
   parameter int SEL_W = 4
) (
   input  logic [1:0]       mode_i,
   input  logic [SEL_W-1:0] stat_i,
   input  logic [SEL_W-1:0] mask_i,
   input  logic [SEL_W-1:0] val_i,
   output logic             hit_o
);
   logic match;

   always_comb begin
      match = ((stat_i & mask_i) == (val_i & mask_i));
      case (mode_i)
         2'd0:    hit_o = 1'b0;
         2'd1:    hit_o = match;
         2'd2:    hit_o = !match;
         default: hit_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/dsq_status.sv
module dsq_status
   import dsq_pkg::*;
#(
   parameter int DSTAT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               flush_req_i,
   input  logic               wake_req_i,
   input  logic               ev_fetch_i,
   input  logic               ev_stop_i,
   input  logic               ev_kill_i,
   input  logic               ev_fin_i,
   input  logic               bt_val_i,
   input  logic [DSTAT_W-1:0] dev_stat_i,
   output logic               run_q_o,
   output logic               active_o,
   output logic [STAT_W-1:0]  status_o
);
   logic run_q, act, dead, bt, flush, wake;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0; act <= 1'b0; dead <= 1'b0;
         bt <= 1'b0; flush <= 1'b0; wake <= 1'b0;
      end else begin
         run_q <= run_i;
         if (run_i && !run_q) begin
            act <= 1'b1; dead <= 1'b0;
         end else if (!run_i && run_q) begin
            act <= 1'b0; dead <= 1'b0;
         end
         if (flush_req_i) flush <= 1'b1;
         if (wake_req_i)  wake  <= 1'b1;
         if (ev_fetch_i)  wake  <= 1'b0;
         if (ev_fin_i) begin
            flush <= 1'b0;
            bt    <= bt_val_i;
         end
         if (ev_stop_i) begin
            act <= 1'b0; dead <= 1'b0; flush <= 1'b0;
         end
         if (ev_kill_i) begin
            dead <= 1'b1; act <= 1'b0;
         end
      end
   end

   always_comb begin
      status_o                = '0;
      status_o[DSTAT_W-1:0]   = dev_stat_i;
      status_o[ST_RUN]        = run_q;
      status_o[ST_ACT]        = act;
      status_o[ST_DEAD]       = dead;
      status_o[ST_BT]         = bt;
      status_o[ST_FLUSH]      = flush;
      status_o[ST_WAKE]       = wake;
   end

   assign run_q_o  = run_q;
   assign active_o = act;
endmodule

// File: rtl/dsq_engine.sv
module dsq_engine
   import dsq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DSTAT_W = 8,
   parameter int SEL_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               flush_req_i,
   input  logic               wake_req_i,
   input  logic               ptr_wr_i,
   input  logic [ADDR_W-1:0]  ptr_wdata_i,
   output logic [ADDR_W-1:0]  cmd_ptr_o,
   output logic [15:0]        status_o,
   input  logic [DSTAT_W-1:0] dev_stat_i,
   input  logic [SEL_W-1:0]   wait_mask_i,
   input  logic [SEL_W-1:0]   wait_val_i,
   input  logic [SEL_W-1:0]   irq_mask_i,
   input  logic [SEL_W-1:0]   irq_val_i,
   input  logic [SEL_W-1:0]   br_mask_i,
   input  logic [SEL_W-1:0]   br_val_i,
   output logic               mem_req_o,
   output logic               mem_we_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   output logic [3:0]         mem_be_o,
   output logic [31:0]        mem_wdata_o,
   input  logic [31:0]        mem_rdata_i,
   input  logic               mem_ack_i,
   output logic               xfer_start_o,
   output logic               xfer_out_o,
   output logic               xfer_last_o,
   output logic [2:0]         xfer_key_o,
   output logic [ADDR_W-1:0]  xfer_addr_o,
   output logic [15:0]        xfer_len_o,
   input  logic               xfer_done_i,
   input  logic [15:0]        xfer_resid_i,
   output logic               irq_o,
   input  logic               irq_ack_i
);
   localparam int NCOND = 3;           // 0 wait, 1 interrupt, 2 branch
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("ADDR_W must lie in 8..32");
   end
   if (DSTAT_W < SEL_W || DSTAT_W > 8) begin : g_bad_ds
      $error("DSTAT_W must lie in SEL_W..8");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must lie in 1..4");
   end

   dsq_state_e        state;
   logic [1:0]        wcnt;
   logic [ADDR_W-1:0] ptr;
   logic [15:0]       d_cnt;
   logic [3:0]        d_op;
   logic [2:0]        d_key;
   logic [1:0]        d_mode [NCOND];
   logic [ADDR_W-1:0] d_addr;
   logic [31:0]       d_dep;
   logic [15:0]       resid;
   logic [15:0]       wb_stat;
   logic              irq_q;

   logic [SEL_W-1:0]  c_mask [NCOND];
   logic [SEL_W-1:0]  c_val  [NCOND];
   logic [NCOND-1:0]  hit;
   logic              run_q, active, go;
   logic              is_xfer, is_word, bad;
   logic              ev_fetch, ev_kill, ev_stop, ev_fin, br_take;
   logic [31:0]       ld_merge;

   assign c_mask[0] = wait_mask_i; assign c_val[0] = wait_val_i;
   assign c_mask[1] = irq_mask_i;  assign c_val[1] = irq_val_i;
   assign c_mask[2] = br_mask_i;   assign c_val[2] = br_val_i;

   for (genvar g = 0; g < NCOND; g++) begin : g_cond
      dsq_cond #(.SEL_W(SEL_W)) u_cond (
         .mode_i (d_mode[g]),
         .stat_i (dev_stat_i[SEL_W-1:0]),
         .mask_i (c_mask[g]),
         .val_i  (c_val[g]),
         .hit_o  (hit[g])
      );
   end

   // decode of the latched descriptor
   always_comb begin
      is_xfer  = (d_op[3:2] == 2'b00);
      is_word  = (d_op == OP_STORE) || (d_op == OP_LOAD);
      bad      = d_op[3] || (d_key == KEY_BAD)
              || (is_xfer && (d_key > 3'd3 || d_addr == '0))
              || (is_word && d_key != KEY_SYS);
      go       = run_q && active;
      ev_fetch = (state == S_IDLE) && go;
      ev_kill  = (state == S_DECODE) && bad;
      ev_stop  = (state == S_DECODE) && !bad && (d_op == OP_STOP);
      ev_fin   = (state == S_FIN);
      br_take  = !is_word && hit[2];
      for (int b = 0; b < 4; b++)
         ld_merge[8*b +: 8] = word_be(d_cnt[2:0])[b] ? mem_rdata_i[8*b +: 8]
                                                       : d_dep[8*b +: 8];
   end

   dsq_status #(.DSTAT_W(DSTAT_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run_i),
      .flush_req_i (flush_req_i),
      .wake_req_i  (wake_req_i),
      .ev_fetch_i  (ev_fetch),
      .ev_stop_i   (ev_stop),
      .ev_kill_i   (ev_kill),
      .ev_fin_i    (ev_fin),
      .bt_val_i    (br_take),
      .dev_stat_i  (dev_stat_i),
      .run_q_o     (run_q),
      .active_o    (active),
      .status_o    (status_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE; wcnt <= '0; ptr <= '0;
         d_cnt <= '0; d_op <= '0; d_key <= '0; d_addr <= '0; d_dep <= '0;
         for (int i = 0; i < NCOND; i++) d_mode[i] <= '0;
         resid <= '0; wb_stat <= '0; irq_q <= 1'b0;
      end else begin
         if (ev_kill || (ev_fin && hit[1])) irq_q <= 1'b1;
         else if (irq_ack_i)                irq_q <= 1'b0;
         case (state)
            S_IDLE: begin
               if (ptr_wr_i && !run_q && !active)
                  ptr <= {ptr_wdata_i[ADDR_W-1:4], 4'b0000};
               if (go) begin
                  state <= S_FETCH;
                  wcnt  <= '0;
               end
            end
            S_FETCH: if (mem_ack_i) begin
               case (wcnt)
                  2'd0: begin
                     d_cnt     <= mem_rdata_i[15:0];
                     d_op      <= mem_rdata_i[31:28];
                     d_key     <= mem_rdata_i[26:24];
                     d_mode[1] <= mem_rdata_i[21:20];
                     d_mode[2] <= mem_rdata_i[19:18];
                     d_mode[0] <= mem_rdata_i[17:16];
                  end
                  2'd1:    d_addr <= mem_rdata_i[ADDR_W-1:0];
                  default: d_dep  <= mem_rdata_i;
               endcase
               if (wcnt == 2'd2) state <= S_DECODE;
               else              wcnt  <= wcnt + 2'd1;
            end
            S_DECODE: begin
               resid <= '0;
               if (bad || d_op == OP_STOP) state <= S_IDLE;
               else if (is_xfer)           state <= S_XSTART;
               else if (is_word)           state <= S_MEMOP;
               else                        state <= S_COND;
            end
            S_XSTART: state <= S_XWAIT;
            S_XWAIT: if (xfer_done_i) begin
               resid <= xfer_resid_i;
               state <= S_COND;
            end
            S_MEMOP: if (mem_ack_i) begin
               if (d_op == OP_LOAD) d_dep <= ld_merge;
               state <= S_COND;
            end
            S_COND: if (!hit[0]) begin
               wb_stat <= status_o;
               wcnt    <= '0;
               state   <= S_WB;
            end
            S_WB: if (mem_ack_i) begin
               if (wcnt == 2'd1) state <= S_FIN;
               else              wcnt  <= 2'd1;
            end
            S_FIN: begin
               ptr   <= br_take ? d_dep[ADDR_W-1:0] : ptr + STEP;
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = ptr;
      mem_be_o    = 4'b1111;
      mem_wdata_o = '0;
      case (state)
         S_FETCH: begin
            mem_req_o  = 1'b1;
            mem_addr_o = ptr + ADDR_W'({wcnt, 2'b00});
         end
         S_MEMOP: begin
            mem_req_o   = 1'b1;
            mem_we_o    = (d_op == OP_STORE);
            mem_addr_o  = d_addr;
            mem_be_o    = word_be(d_cnt[2:0]);
            mem_wdata_o = d_dep;
         end
         S_WB: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = ptr + ADDR_W'(wcnt[0] ? 12 : 8);
            mem_wdata_o = wcnt[0] ? {wb_stat, resid} : d_dep;
         end
         default: ;
      endcase
   end

   assign xfer_start_o = (state == S_XSTART);
   assign xfer_out_o   = !d_op[1];
   assign xfer_last_o  = d_op[0];
   assign xfer_key_o   = d_key;
   assign xfer_addr_o  = d_addr;
   assign xfer_len_o   = d_cnt;
   assign cmd_ptr_o    = ptr;
   assign irq_o        = irq_q;

   // R2: an unacknowledged request holds its address
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
   // R4: a kill leaves DEAD set, ACTIVE clear and the interrupt high
   a_r4_kill_state: assert property (@(posedge clk) disable iff (!rst_n)
      ev_kill |=> status_o[ST_DEAD] && !status_o[ST_ACT] && irq_o);
   // R5: the transfer start is a single-cycle pulse
   a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start_o |=> !xfer_start_o);
   // R7: no memory traffic while the wait condition stalls the engine
   a_r7_wait_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_COND) && hit[0] |=> !mem_req_o);
   // R8: write-back goes only to offsets 8 and 12 of the descriptor
   a_r8_wb_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WB) && mem_req_o |->
         mem_we_o && (mem_addr_o[3:0] == 4'd8 || mem_addr_o[3:0] == 4'd12));
   // R11: word accesses use only the three legal byte-enable patterns
   a_r11_word_be: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_MEMOP) |->
         (mem_be_o == 4'b0001 || mem_be_o == 4'b0011 || mem_be_o == 4'b1111));
   // R12: a stop clears ACTIVE and FLUSH and keeps the pointer
   a_r12_stop_state: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> !status_o[ST_ACT] && !status_o[ST_FLUSH] && $stable(cmd_ptr_o));
   // R13: the interrupt level drops only on acknowledge
   a_r13_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(irq_ack_i));
endmodule

// File: tb/sim_dsq_engine.sv
module sim_dsq_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_i = 0, flush_req_i = 0, wake_req_i = 0, ptr_wr_i = 0;
   logic [31:0] ptr_wdata_i = '0;
   logic [31:0] cmd_ptr_o;
   logic [15:0] status_o;
   logic [7:0]  dev_stat_i = '0;
   logic [3:0]  wait_mask_i = 0, wait_val_i = 0, irq_mask_i = 0, irq_val_i = 0;
   logic [3:0]  br_mask_i = 0, br_val_i = 0;
   logic        mem_req_o, mem_we_o, mem_ack_i = 0;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
   logic [3:0]  mem_be_o;
   logic        xfer_start_o, xfer_out_o, xfer_last_o, xfer_done_i = 0;
   logic [2:0]  xfer_key_o;
   logic [31:0] xfer_addr_o;
   logic [15:0] xfer_len_o, xfer_resid_i = '0;
   logic        irq_o, irq_ack_i = 0;

   int nchk = 0, nerr = 0, wr_cnt = 0, dev_cnt = 0, starts = 0;
   logic [31:0] mem [64];
   logic        c_out, c_last;
   logic [2:0]  c_key;
   logic [31:0] c_addr;
   logic [15:0] c_len;
   logic        bt_m = 0;

   always #4 clk = ~clk;

   dsq_engine u0 (.*);

   // memory model: random acknowledge delay, byte-lane writes
   always @(negedge clk) begin
      mem_ack_i   = mem_req_o && ($urandom_range(0, 2) != 0);
      mem_rdata_i = mem[mem_addr_o[7:2]];
   end
   always @(posedge clk) begin
      if (mem_req_o && mem_ack_i && mem_we_o) begin
         wr_cnt++;
         for (int b = 0; b < 4; b++)
            if (mem_be_o[b]) mem[mem_addr_o[7:2]][8*b +: 8] = mem_wdata_o[8*b +: 8];
      end
   end
   // stream device model: completes three cycles after the start pulse
   always @(negedge clk) begin
      xfer_done_i = 1'b0;
      if (dev_cnt != 0) begin
         dev_cnt--;
         if (dev_cnt == 0) xfer_done_i = 1'b1;
      end
      if (xfer_start_o) begin
         c_out = xfer_out_o; c_last = xfer_last_o; c_key = xfer_key_o;
         c_addr = xfer_addr_o; c_len = xfer_len_o; dev_cnt = 3; starts++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic hit(input logic [1:0] m, input logic [3:0] mk,
                                input logic [3:0] v, input logic [7:0] ds);
      logic t;
      t = ((ds[3:0] & mk) == (v & mk));
      case (m)
         2'd0: return 1'b0;
         2'd1: return t;
         2'd2: return !t;
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [15:0] stw(input logic run, act, dead, bt, fl, wk,
                                      input logic [7:0] ds);
      return {run, act, dead, bt, fl, wk, 2'b00, ds};
   endfunction

   function automatic logic [31:0] cw(input logic [3:0] op, input logic [2:0] key,
                                     input logic [1:0] im, bm, wm, input logic [15:0] cnt);
      return {op, 1'b0, key, 2'b00, im, bm, wm, cnt};
   endfunction

   task automatic set_ptr(input logic [31:0] p);
      @(negedge clk); ptr_wr_i = 1'b1; ptr_wdata_i = p;
      @(negedge clk); ptr_wr_i = 1'b0;
   endtask

   task automatic run_wait();
      run_i = 1'b1;
      repeat (3) @(negedge clk);
      while (status_o[14]) @(negedge clk);
   endtask

   task automatic run_off();
      @(negedge clk); run_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic put_stop(input int a);
      mem[a/4] = cw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0, 16'd0);
   endtask

   task automatic kill_case(input string tag, input logic [31:0] w0, input logic [31:0] w1);
      int w;
      mem[8] = w0; mem[9] = w1; mem[10] = 32'h80; mem[11] = 32'hDEADBEEF;
      set_ptr(32'h20);
      w = wr_cnt;
      irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
      run_wait();
      chk({"R4 dead ", tag}, status_o[13], 1'b1);
      chk({"R4 active ", tag}, status_o[14], 1'b0);
      chk({"R4 irq ", tag}, irq_o, 1'b1);
      chk({"R4 no write ", tag}, wr_cnt - w, 0);
      chk({"R3 ptr kept ", tag}, cmd_ptr_o, 32'h20);
      run_off();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5EED));
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", status_o, 16'h0);
      chk("R1 ptr", cmd_ptr_o, 32'h0);
      chk("R1 irq", irq_o, 1'b0);
      chk("R1 mem_req", mem_req_o, 1'b0);
      chk("R1 start", xfer_start_o, 1'b0);

      // R2 alignment, R9 flush kept through write-back, R13 wake cleared
      begin
         int w;
         mem[4] = cw(4'd6, 3'd0, 2'd0, 2'd0, 2'd0, 16'h0);
         mem[5] = 32'h0; mem[6] = 32'h1234_5678; mem[7] = 32'hFFFF_FFFF;
         put_stop(32'h20);
         set_ptr(32'h13);
         chk("R2 aligned ptr", cmd_ptr_o, 32'h10);
         dev_stat_i = 8'hA5;
         @(negedge clk); flush_req_i = 1; wake_req_i = 1;
         @(negedge clk); flush_req_i = 0; wake_req_i = 0;
         chk("R13 wake set", status_o[10], 1'b1);
         w = wr_cnt;
         run_wait();
         chk("R8 dep wb", mem[6], 32'h1234_5678);
         chk("R8 R9 R13 stat wb", mem[7], {stw(1,1,0,0,1,0,8'hA5), 16'h0});
         chk("R9 flush cleared", status_o[11], 1'b0);
         chk("R13 wake cleared", status_o[10], 1'b0);
         chk("R10 advance", cmd_ptr_o, 32'h20);
         chk("R8 two writes", wr_cnt - w, 2);
         chk("R9 no irq", irq_o, 1'b0);
         set_ptr(32'h50);
         chk("R2 write ignored while RUN", cmd_ptr_o, 32'h20);
         run_off();
      end

      // R7 wait stall
      begin
         int w;
         mem[8] = cw(4'd6, 3'd1, 2'd0, 2'd0, 2'd1, 16'h0);
         mem[9] = 0; mem[10] = 32'hCAFE; mem[11] = 0;
         put_stop(32'h30);
         wait_mask_i = 4'h1; wait_val_i = 4'h1; dev_stat_i = 8'h01;
         set_ptr(32'h20);
         w = wr_cnt;
         run_i = 1'b1;
         repeat (40) @(negedge clk);
         chk("R7 stalled no write", wr_cnt - w, 0);
         chk("R7 still active", status_o[14], 1'b1);
         dev_stat_i = 8'h00;
         repeat (2) @(negedge clk);
         while (status_o[14]) @(negedge clk);
         chk("R7 released wb", mem[11], {stw(1,1,0,0,0,0,8'h00), 16'h0});
         chk("R7 ptr", cmd_ptr_o, 32'h30);
         run_off();
         wait_mask_i = 0; wait_val_i = 0;
      end

      // R3 R4 invalid commands
      kill_case("xfer addr zero", cw(4'd0, 3'd0, 0, 0, 0, 16'd8), 32'h0);
      kill_case("key4 nop", cw(4'd6, 3'd4, 0, 0, 0, 16'd0), 32'h100);
      kill_case("load key5", cw(4'd5, 3'd5, 0, 0, 0, 16'd4), 32'hC0);
      kill_case("op9", cw(4'd9, 3'd0, 0, 0, 0, 16'd0), 32'h100);
      kill_case("input key7", cw(4'd3, 3'd7, 0, 0, 0, 16'd8), 32'h100);
      // R13 interrupt level held until acknowledged
      repeat (5) @(negedge clk);
      chk("R13 irq held", irq_o, 1'b1);
      irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
      chk("R13 irq cleared", irq_o, 1'b0);

      // R12 stop at the head of a chain
      begin
         int w;
         put_stop(32'h30);
         set_ptr(32'h30);
         @(negedge clk); flush_req_i = 1; @(negedge clk); flush_req_i = 0;
         w = wr_cnt;
         run_wait();
         chk("R12 flush cleared", status_o[11], 1'b0);
         chk("R12 dead clear", status_o[13], 1'b0);
         chk("R12 ptr kept", cmd_ptr_o, 32'h30);
         chk("R12 no write", wr_cnt - w, 0);
         run_off();
      end

      // random commands: R5 R6 R8 R9 R10 R11
      for (int it = 0; it < 40; it++) begin
         int kind, s0;
         logic [3:0] op; logic [2:0] key; logic [1:0] im, bm, wm;
         logic [15:0] cnt, rs, exp_res; logic [31:0] addr, dep, ld, exp_dep, exp_mem;
         logic taken, exp_irq; logic [3:0] be;
         kind = $urandom_range(0, 3);
         dev_stat_i = 8'($urandom);
         irq_mask_i = 4'($urandom); irq_val_i = 4'($urandom);
         br_mask_i = 4'($urandom); br_val_i = 4'($urandom);
         wait_mask_i = 4'($urandom); wait_val_i = 4'($urandom);
         im = 2'($urandom); bm = 2'($urandom); wm = 2'($urandom);
         if (hit(wm, wait_mask_i, wait_val_i, dev_stat_i)) wm = 2'd0;
         cnt = 16'($urandom); rs = 16'($urandom); ld = $urandom;
         dep = 32'h80; addr = 32'h100 | 32'($urandom_range(1, 255));
         case (kind)
            0: begin op = 4'($urandom_range(0, 3)); key = 3'($urandom_range(0, 3)); end
            1: begin op = 4'd6; key = 3'($urandom_range(5, 7)); end
            2: begin op = 4'd5; key = 3'd6; addr = 32'hC0; dep = $urandom; end
            default: begin op = 4'd4; key = 3'd6; addr = 32'hC0; dep = $urandom; end
         endcase
         mem[8] = cw(op, key, im, bm, wm, cnt); mem[9] = addr; mem[10] = dep; mem[11] = 0;
         put_stop(32'h30); put_stop(32'h80); mem[48] = ld;
         xfer_resid_i = rs;
         be = cnt[2] ? 4'hF : (cnt[1] ? 4'h3 : 4'h1);
         exp_dep = dep; exp_mem = ld;
         for (int b = 0; b < 4; b++) if (be[b]) begin
            if (kind == 2) exp_dep[8*b +: 8] = ld[8*b +: 8];
            if (kind == 3) exp_mem[8*b +: 8] = dep[8*b +: 8];
         end
         exp_res = (kind == 0) ? rs : 16'h0;
         taken = (kind < 2) && hit(bm, br_mask_i, br_val_i, dev_stat_i);
         exp_irq = hit(im, irq_mask_i, irq_val_i, dev_stat_i);
         set_ptr(32'h20);
         irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
         s0 = starts;
         run_wait();
         chk("R8 dep wb", mem[10], exp_dep);
         chk("R8 R5 stat/resid wb", mem[11], {stw(1,1,0,bt_m,0,0,dev_stat_i), exp_res});
         chk("R10 R6 ptr", cmd_ptr_o, taken ? 32'h80 : 32'h30);
         chk("R10 BT", status_o[12], taken);
         chk("R9 R6 irq", irq_o, exp_irq);
         if (kind == 0) begin
            chk("R5 one start", starts - s0, 1);
            chk("R5 fields", {c_out, c_last, 1'b0, c_key, c_addr[23:0]},
                {!op[1], op[0], 1'b0, key, addr[23:0]});
            chk("R5 len", c_len, cnt);
         end
         if (kind == 3) chk("R11 store lanes", mem[48], exp_mem);
         if (kind == 2) chk("R11 load merge", mem[10], exp_dep);
         bt_m = taken;
         run_off();
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule